// File: doc/BRIEF.md
# Serial CORDIC Sine/Cosine Oscillator

This block is a numerically controlled oscillator that produces a signed sine word and a signed cosine word from a phase accumulator. Instead of a lookup table, it uses one iterative CORDIC shift-add stage. That stage is reused for N clock cycles per sample, so a new sine/cosine pair leaves the block once every N enabled cycles, where N is the output magnitude precision.

A phase accumulator adds the programmable step once per sample. The top two bits of the truncated phase select a quadrant. The residual angle is rotated within the first quadrant, starting from a vector pre-scaled by the inverse CORDIC gain. After rotation, the result is rounded, clamped and remapped to the full circle. The clock enable stalls the whole block. Every latency figure counts only the cycles in which the enable is high.

Top module: `serial_cordic_nco`

## Requirements
- R1: After the first sample, out_valid pulses exactly once every N enabled clock cycles.
- R2: The first out_valid pulse follows the rising edge that is the (2N+2)-th enabled edge after reset is released.
- R3: out_valid is high for a single clock cycle per sample.
- R4: Each sample is checked against A·cos(θ) and A·sin(θ), where A = 2^(N-1)-1 and θ is 2π times the top N+2 accumulator bits divided by 2^(N+2). Both words must lie within 8 LSB of these values (N = 16).
- R5: The phase of sample k is the modulo-2^PW sum of the phase_step values present at the enabled edges numbered N, 2N, …, kN. Sample 0 has phase 0.
- R6: The top two phase bits select the quadrant (00: 0–90°, 01: 90–180°, 10: 180–270°, 11: 270–360°). The signs and the sine/cosine swap of every output follow that quadrant.
- R7: While ce is low, no sample is produced, out_valid stays low and the outputs keep their values. The clock cycles in which ce is low do not count toward R1 or R2.
- R8: During reset, out_valid, sin_out and cos_out are all zero.
- R9: The outputs are clamped to ±(2^(N-1)-1). The code -2^(N-1) never appears, even at the 0°, 90°, 180° and 270° axis points.
- R10: sin_out and cos_out change only in the cycle in which out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low stalls every register of the block |
| phase_step | input | PW | Phase increment added once per sample |
| sin_out | output | N | Signed sine sample |
| cos_out | output | N | Signed cosine sample |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
At the last iteration edge of each frame, three things happen in one cycle: the engine hands its finished vector to the output path, it loads the next folded phase, and the accumulator adds phase_step. The bench therefore changes phase_step and toggles ce on pseudo-random cycles, and those changes land on frame boundaries. It then judges each sample against a behavioural model, which records the accumulator value only at enabled edges whose count is a multiple of N. A second collision, ce falling in the cycle that would raise out_valid, is produced by the same pattern. That case is judged by the pulse arriving on the next enabled edge, with the outputs unchanged in between.

// File: rtl/scn_pkg.sv
`timescale 1ns/1ps
package scn_pkg;

   typedef enum logic [1:0] {
      QD_FIRST  = 2'd0,
      QD_SECOND = 2'd1,
      QD_THIRD  = 2'd2,
      QD_FOURTH = 2'd3
   } quad_e;

   localparam real PI_R = 3.14159265358979323846;

   // arctangent of 2^-i expressed as a fraction of one full turn
   function automatic real atan_turns(input int i);
      real x;
      real xsq;
      real term;
      real acc;
      if (i == 0) return 0.125;
      x    = 1.0 / (2.0 ** i);
      xsq  = x * x;
      term = x;
      acc  = 0.0;
      for (int k = 0; k < 40; k++) begin
         acc  = acc + (((k % 2) == 0) ? term : -term) / (2 * k + 1);
         term = term * xsq;
      end
      return acc / (2.0 * PI_R);
   endfunction

   // reciprocal of the CORDIC gain after n iterations
   function automatic real cordic_kinv(input int n);
      real p;
      p = 1.0;
      for (int i = 0; i < n; i++)
         p = p / $sqrt(1.0 + 1.0 / (4.0 ** i));
      return p;
   endfunction

endpackage

// File: rtl/scn_phase_acc.sv
`timescale 1ns/1ps
module scn_phase_acc #(
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [PW-1:0] step,
   output logic [PW-1:0] phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase <= '0;
      else if (adv) phase <= phase + step;
   end

endmodule

// File: rtl/scn_cordic_core.sv
`timescale 1ns/1ps
module scn_cordic_core
   import scn_pkg::*;
#(
   parameter int N  = 16,
   parameter int G  = 3,
   parameter int AW = N + 2,
   parameter int DW = N + G + 1,
   parameter int CW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce,
   input  logic                 load,
   input  logic [CW-1:0]        iter,
   input  logic [AW-1:0]        angle,
   output logic signed [DW-1:0] res_x,
   output logic signed [DW-1:0] res_y,
   output quad_e                res_q
);

   localparam int ZW = AW;
   localparam int BW = (DW > ZW) ? DW : ZW;
   localparam logic signed [ZW-1:0] QTR = {{(ZW-1){1'b0}}, 1'b1} << (AW - 2);

   function automatic logic [BW-1:0] to_bits(input real v);
      logic [BW-1:0] r;
      real rem;
      r   = '0;
      rem = v;
      for (int b = BW - 1; b >= 0; b--) begin
         if (rem >= 2.0 ** b) begin
            r[b] = 1'b1;
            rem  = rem - 2.0 ** b;
         end
      end
      if (rem >= 0.5) r = r + 1'b1;
      return r;
   endfunction

   localparam logic [BW-1:0] X0_FULL =
      to_bits(cordic_kinv(N) * (2.0 ** (N - 1) - 1.0) * (2.0 ** G));
   localparam logic signed [DW-1:0] X0 = $signed(X0_FULL[DW-1:0]);

   logic signed [ZW-1:0] atan_tab [N];

   for (genvar g = 0; g < N; g++) begin : g_atan
      localparam logic [BW-1:0] A_FULL = to_bits(atan_turns(g) * (2.0 ** AW));
      assign atan_tab[g] = $signed(A_FULL[ZW-1:0]);
   end

   logic signed [DW-1:0] x_r, y_r, x_nx, y_nx, xs, ys;
   logic signed [ZW-1:0] z_r, z_nx;
   quad_e                q_r;

   assign xs = x_r >>> iter;
   assign ys = y_r >>> iter;

   always_comb begin
      if (!z_r[ZW-1]) begin
         x_nx = x_r - ys;
         y_nx = y_r + xs;
         z_nx = z_r - atan_tab[iter];
      end else begin
         x_nx = x_r + ys;
         y_nx = y_r - xs;
         z_nx = z_r + atan_tab[iter];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_r   <= '0;
         y_r   <= '0;
         z_r   <= '0;
         q_r   <= QD_FIRST;
         res_x <= '0;
         res_y <= '0;
         res_q <= QD_FIRST;
      end else if (ce) begin
         if (load) begin
            res_x <= x_nx;
            res_y <= y_nx;
            res_q <= q_r;
            x_r   <= X0;
            y_r   <= '0;
            z_r   <= {2'b00, angle[AW-3:0]};
            q_r   <= quad_e'(angle[AW-1 -: 2]);
         end else begin
            x_r <= x_nx;
            y_r <= y_nx;
            z_r <= z_nx;
         end
      end
   end

   AST_Z_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (z_r < QTR) && (z_r > -QTR)); // R4

endmodule

// File: rtl/scn_quad_fix.sv
`timescale 1ns/1ps
module scn_quad_fix
   import scn_pkg::*;
#(
   parameter int N  = 16,
   parameter int G  = 3,
   parameter int DW = N + G + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce,
   input  logic signed [DW-1:0] vx,
   input  logic signed [DW-1:0] vy,
   input  quad_e                quad,
   output logic signed [N-1:0]  cos_r,
   output logic signed [N-1:0]  sin_r
);

   localparam logic signed [DW-1:0] LIM  = ({{(DW-1){1'b0}}, 1'b1} << (N - 1)) - 1'b1;
   localparam logic signed [DW-1:0] HALF = {{(DW-1){1'b0}}, 1'b1} << (G - 1);

   function automatic logic signed [N-1:0] shrink(input logic signed [DW-1:0] v);
      logic signed [DW-1:0] r;
      r = (v + HALF) >>> G;
      if (r > LIM)       r = LIM;
      else if (r < -LIM) r = -LIM;
      return r[N-1:0];
   endfunction

   logic signed [N-1:0] c_s, s_s, c_nx, s_nx;

   assign c_s = shrink(vx);
   assign s_s = shrink(vy);

   always_comb begin
      unique case (quad)
         QD_FIRST:  begin c_nx =  c_s; s_nx =  s_s; end
         QD_SECOND: begin c_nx = -s_s; s_nx =  c_s; end
         QD_THIRD:  begin c_nx = -c_s; s_nx = -s_s; end
         default:   begin c_nx =  s_s; s_nx = -c_s; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cos_r <= '0;
         sin_r <= '0;
      end else if (ce) begin
         cos_r <= c_nx;
         sin_r <= s_nx;
      end
   end

endmodule

// File: rtl/serial_cordic_nco.sv
`timescale 1ns/1ps
module serial_cordic_nco
   import scn_pkg::*;
#(
   parameter int N  = 16,
   parameter int G  = 3,
   parameter int PW = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic [PW-1:0]       phase_step,
   output logic signed [N-1:0] sin_out,
   output logic signed [N-1:0] cos_out,
   output logic                out_valid
);

   localparam int AW = N + 2;
   localparam int DW = N + G + 1;
   localparam int CW = $clog2(N);
   localparam int TW = $clog2(2 * N + 4) + 1;
   localparam logic [TW-1:0] FIRST_AT = TW'(2 * N + 2);
   localparam logic [TW-1:0] SAT_AT   = TW'(2 * N + 3);
   localparam logic signed [N-1:0] MIN_CODE = {1'b1, {(N-1){1'b0}}};

   if (N < 8 || N > 128) begin : g_bad_n
      $error("serial_cordic_nco: N must lie in 8..128");
   end
   if (PW < N + 2) begin : g_bad_pw
      $error("serial_cordic_nco: PW must be at least N+2");
   end
   if (G < 1 || G > 8) begin : g_bad_g
      $error("serial_cordic_nco: G must lie in 1..8");
   end

   logic [CW-1:0] iter;
   logic          frame_end, primed, v1, v2;
   logic [PW-1:0] acc;
   logic signed [DW-1:0] rx, ry;
   quad_e         rq;
   logic signed [N-1:0] fc, fs;

   assign frame_end = ce && (iter == CW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iter   <= '0;
         primed <= 1'b0;
         v1     <= 1'b0;
         v2     <= 1'b0;
      end else if (ce) begin
         iter   <= frame_end ? '0 : iter + 1'b1;
         primed <= primed | frame_end;
         v1     <= frame_end & primed;
         v2     <= v1;
      end
   end

   scn_phase_acc #(.PW(PW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (frame_end),
      .step  (phase_step),
      .phase (acc)
   );

   scn_cordic_core #(.N(N), .G(G), .AW(AW), .DW(DW), .CW(CW)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .load  (frame_end),
      .iter  (iter),
      .angle (acc[PW-1 -: AW]),
      .res_x (rx),
      .res_y (ry),
      .res_q (rq)
   );

   scn_quad_fix #(.N(N), .G(G), .DW(DW)) u_fix (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (ce),
      .vx    (rx),
      .vy    (ry),
      .quad  (rq),
      .cos_r (fc),
      .sin_r (fs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         sin_out   <= '0;
         cos_out   <= '0;
      end else begin
         out_valid <= ce & v2;
         if (ce && v2) begin
            sin_out <= fs;
            cos_out <= fc;
         end
      end
   end

   // checker state: enabled edges since reset and since the last pulse
   logic [TW-1:0] ce_total, gap;
   logic          seen_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_total   <= '0;
         gap        <= '0;
         seen_valid <= 1'b0;
      end else begin
         if (ce && ce_total != SAT_AT) ce_total <= ce_total + 1'b1;
         if (out_valid)  gap <= ce ? TW'(1) : '0;
         else if (ce)    gap <= gap + 1'b1;
         if (out_valid)  seen_valid <= 1'b1;
      end
   end

   AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !seen_valid |-> ce_total == FIRST_AT); // R2
   AST_SAMPLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && seen_valid |-> gap == TW'(N)); // R1
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R3
   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> !out_valid && $stable(sin_out) && $stable(cos_out)); // R7
   AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sin_out != MIN_CODE) && (cos_out != MIN_CODE)); // R9
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(sin_out) && $stable(cos_out)); // R10

endmodule

// File: tb/serial_cordic_nco_tb.sv
`timescale 1ns/1ps
module serial_cordic_nco_tb;

   localparam int  N   = 16;
   localparam int  G   = 3;
   localparam int  PW  = 24;
   localparam int  AW  = N + 2;
   localparam real TOL = 8.0;
   localparam real AMP = 32767.0;
   localparam real PI2 = 6.28318530717958647692;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0;
   logic [PW-1:0] phase_step = '0;
   logic signed [N-1:0] sin_out, cos_out;
   logic out_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int e;
   logic [PW-1:0] acc_m;
   logic [PW-1:0] pq [$];
   logic signed [N-1:0] prev_s, prev_c;
   logic [31:0] seed = 32'h1234_abcd;

   always #4 clk = ~clk;

   serial_cordic_nco #(.N(N), .G(G), .PW(PW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce         (ce),
      .phase_step (phase_step),
      .sin_out    (sin_out),
      .cos_out    (cos_out),
      .out_valid  (out_valid)
   );

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input real act, input real expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic logic [31:0] next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   task automatic do_reset(input int cycles);
      rst_n = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0 && sin_out == 0 && cos_out == 0, "R8",
               "reset outputs nonzero", real'(out_valid) + rabs(real'(sin_out)) + rabs(real'(cos_out)), 0.0);
      end
      rst_n  = 1'b1;
      e      = 0;
      acc_m  = '0;
      pq.delete();
      prev_s = '0;
      prev_c = '0;
   endtask

   task automatic step(input logic ce_v, input logic [PW-1:0] inc_v, input string vtag);
      bit exp_v;
      logic [PW-1:0] ph;
      real th, ec, es;
      string vt;
      ce = ce_v;
      phase_step = inc_v;
      ph = '0;
      @(posedge clk);
      exp_v = 1'b0;
      if (ce_v) begin
         e++;
         if (e % N == 0) begin
            pq.push_back(acc_m);
            acc_m = acc_m + inc_v;
         end
         if ((e % N == 2) && (e >= 2 * N + 2)) begin
            exp_v = 1'b1;
            ph = pq.pop_front();
         end
      end
      @(negedge clk);
      vt = (e == 2 * N + 2 && exp_v) ? "R2" : (!ce_v ? "R7" : (exp_v ? "R1" : "R3"));
      check(out_valid == exp_v, vt, "out_valid", real'(out_valid), real'(exp_v));
      if (exp_v && out_valid) begin
         th = PI2 * real'(ph >> (PW - AW)) / (2.0 ** AW);
         ec = AMP * $cos(th);
         es = AMP * $sin(th);
         check(rabs(real'(cos_out) - ec) <= TOL, vtag, "cos value", real'(cos_out), ec);
         check(rabs(real'(sin_out) - es) <= TOL, vtag, "sin value", real'(sin_out), es);
         if (rabs(ec) > 4.0 * TOL)
            check((ec > 0.0) == (cos_out > 0), "R6", "cos sign", real'(cos_out), ec);
         if (rabs(es) > 4.0 * TOL)
            check((es > 0.0) == (sin_out > 0), "R6", "sin sign", real'(sin_out), es);
         check(sin_out != -16'sd32768 && cos_out != -16'sd32768, "R9", "min code",
               real'(sin_out) < real'(cos_out) ? real'(sin_out) : real'(cos_out), -32767.0);
      end else if (!exp_v) begin
         check(sin_out == prev_s && cos_out == prev_c, ce_v ? "R10" : "R7",
               "outputs moved", real'(sin_out), real'(prev_s));
      end
      prev_s = sin_out;
      prev_c = cos_out;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", e, 0);
         summary();
         $finish;
      end
   end

   initial begin
      ce = 1'b1;
      do_reset(4);

      // R4 R6: steady step sweeping several turns through all quadrants
      for (int i = 0; i < 60 * N; i++) step(1'b1, 24'h0B_1234, "R4");

      // R5 R7: random enable and a step changing on every cycle
      for (int i = 0; i < 800; i++) begin
         logic [31:0] r;
         r = next_rand();
         step(r[7:6] != 2'b00, next_rand() >> 8, "R5");
      end

      // R7: long stall then resume
      for (int i = 0; i < 60; i++) step(1'b0, 24'h05_0000, "R7");
      for (int i = 0; i < 8 * N; i++) step(1'b1, 24'h05_0000, "R4");

      // R9 R6: quarter-turn steps land on the axes
      do_reset(3);
      for (int i = 0; i < 12 * N; i++) step(1'b1, 24'h40_0000, "R9");

      // R9: half-turn steps
      do_reset(2);
      for (int i = 0; i < 8 * N; i++) step(1'b1, 24'h80_0000, "R9");

      // R5: negative step wraps the accumulator below zero
      do_reset(2);
      for (int i = 0; i < 8 * N; i++) step(1'b1, 24'hFF_F000, "R5");

      // R2 R7: stall right after reset, first pulse still counts enabled edges only
      do_reset(2);
      for (int i = 0; i < 30; i++) step(1'b0, 24'h12_3456, "R7");
      for (int i = 0; i < 6 * N; i++) step((i % 3) != 1, 24'h12_3456, "R4");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule